// File: doc/BRIEF.md
# Subcarrier Control Pin Receiver

This block watches a single external control pin whose meaning depends on a 2-bit role selector. In reset role, a low-to-high transition on the pin arms a subcarrier phase reset, and that reset is issued at the next field boundary. The phase then returns to its field-0 value. In serial role, the pin carries a 67-bit frame at two clock cycles per bit. The block keeps bits 0 to 21 of that frame as a new subcarrier frequency word. The word is handed to the oscillator at a line boundary, so the frequency can follow line-length variation from one line to the next.

The pin is asynchronous to the block clock and goes through a synchroniser first. The oscillator is outside this block. It consumes the reset pulse, the frequency word and the update strobe.

Top module: `scpin_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first event, `sc_reset_pulse`, `freq_update` and `freq_word` are all zero.
- R2: `pin_role` encodes 2'b01 as reset role, 2'b10 as serial role, and 2'b00 or 2'b11 as off. In the off roles, pin activity, field starts and line starts produce no pulse and no update. In reset role, no frame is decoded. In serial role, no reset pulse is issued.
- R3: In reset role, a rising edge on the synchronised pin arms a reset. When `field_start` is sampled high while armed, `sc_reset_pulse` is high for exactly the next cycle. A rising edge seen in the same cycle as `field_start` arms for the following field boundary.
- R4: Further rising edges while a reset is already armed still give a single pulse at the boundary. A later boundary gives no second pulse unless the reset is armed again.
- R5: Leaving reset role drops an armed reset. Returning to reset role without a new rising edge gives no pulse at the next boundary.
- R6: In serial role, a rising edge on the synchronised pin while no frame is in progress begins a two-cycle start bit. The 67 frame bits follow, each two cycles long and sampled on its second cycle. Frame bits 0 to 21 form `freq_word`, with frame bit 0 as its LSB. Bits 22 to 66 are discarded.
- R7: Only when a frame has been fully received does the next sampled `line_start` load `freq_word`, with `freq_update` high for the one following cycle. A `line_start` with no completed frame pending changes nothing. `freq_word` holds its value between updates.
- R8: Rising edges on the pin while a frame is in progress do not restart the frame.
- R9: Leaving serial role abandons a frame in progress and discards a completed word that has not yet been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_pin | input | 1 | Shared control pin, asynchronous |
| pin_role | input | 2 | Role selector: 01 reset, 10 serial, 00/11 off |
| field_start | input | 1 | One-cycle pulse at each field boundary |
| line_start | input | 1 | One-cycle pulse at each line boundary |
| sc_reset_pulse | output | 1 | One-cycle subcarrier phase reset request |
| freq_word | output | 22 | Compensated subcarrier frequency word |
| freq_update | output | 1 | One-cycle strobe when `freq_word` takes a new value |

## Verification
The bench covers these corner cases:
- A rising edge in the same cycle as a field boundary. A design that treats it as armed fires one field early.
- Repeated edges before a boundary. A counting design emits several pulses.
- A role change away and back while armed. A design that forgets to clear the armed state then pulses with no fresh edge.

On the serial side, the bench sends frames that toggle inside the frame and carry nonzero data beyond bit 21. A design that restarts on those toggles, or that keeps the wrong slice, loads a wrong word. Line starts come mid-frame, twice after one frame, and after a role toggle. A design that applies a stale or partial word strobes when it should stay quiet.

// File: rtl/scpin_pkg.sv
package scpin_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'b00,
    ROLE_RESET  = 2'b01,
    ROLE_SERIAL = 2'b10,
    ROLE_OFF_HI = 2'b11
  } pin_role_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned FRAME_BITS  = 67;
  localparam int unsigned FREQ_BITS   = 22;

endpackage

// File: rtl/scpin_rst_sync.sv
module scpin_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/scpin_pin_sync.sv
module scpin_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  localparam int unsigned TAPS = STAGES + 1;

  logic [TAPS-1:0] tap_q;
  logic [TAPS-1:0] tap_d;

  always_comb begin
    tap_d = {tap_q[TAPS-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= '0;
    else        tap_q <= tap_d;
  end

  assign level_o = tap_q[STAGES-1];
  assign rise_o  = tap_q[STAGES-1] & ~tap_q[STAGES];
endmodule

// File: rtl/scpin_rst_arm.sv
module scpin_rst_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic role_en,
  input  logic rise_i,
  input  logic field_i,
  output logic pulse_o
);
  logic armed_q, armed_d;
  logic pulse_q, pulse_d;

  always_comb begin
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (!role_en) begin
      armed_d = 1'b0;
    end else if (field_i) begin
      // a boundary consumes the armed reset; an edge now arms the next one
      pulse_d = armed_q;
      armed_d = rise_i;
    end else if (rise_i) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/scpin_rtc_deser.sv
module scpin_rtc_deser #(
  parameter int unsigned FRAME_BITS = 67,
  parameter int unsigned WORD_BITS  = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 role_en,
  input  logic                 level_i,
  input  logic                 rise_i,
  input  logic                 line_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 upd_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic                 busy_q,  busy_d;
  logic                 skip_q,  skip_d;
  logic                 phase_q, phase_d;
  logic [CNT_W-1:0]     cnt_q,   cnt_d;
  logic [WORD_BITS-1:0] cap_q,   cap_d;
  logic [WORD_BITS-1:0] hold_q,  hold_d;
  logic                 full_q,  full_d;
  logic [WORD_BITS-1:0] word_q,  word_d;
  logic                 upd_q,   upd_d;
  logic                 sample_en;
  logic                 apply_en;

  assign sample_en = role_en & busy_q & ~skip_q & phase_q;
  assign apply_en  = role_en & line_i & full_q;

  always_comb begin
    busy_d  = busy_q;
    skip_d  = skip_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cap_d   = cap_q;
    hold_d  = hold_q;
    full_d  = full_q;
    word_d  = word_q;
    upd_d   = 1'b0;

    if (!role_en) begin
      busy_d  = 1'b0;
      skip_d  = 1'b0;
      phase_d = 1'b0;
      cnt_d   = '0;
      full_d  = 1'b0;
    end else begin
      if (apply_en) begin
        word_d = hold_q;
        upd_d  = 1'b1;
        full_d = 1'b0;
      end

      if (busy_q) begin
        if (skip_q) begin
          skip_d = 1'b0;              // second cycle of the start bit
        end else if (!phase_q) begin
          phase_d = 1'b1;             // first cycle of a data bit
        end else begin
          phase_d = 1'b0;
          for (int i = 0; i < int'(WORD_BITS); i++) begin
            if (sample_en && cnt_q == CNT_W'(i)) cap_d[i] = level_i;
          end
          if (cnt_q == LAST_BIT) begin
            busy_d = 1'b0;
            cnt_d  = '0;
            hold_d = cap_d;
            full_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end else if (rise_i) begin
        busy_d  = 1'b1;
        skip_d  = 1'b1;
        phase_d = 1'b0;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      skip_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      cap_q   <= '0;
      hold_q  <= '0;
      full_q  <= 1'b0;
      word_q  <= '0;
      upd_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      skip_q  <= skip_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (sample_en) cap_q <= cap_d;
      hold_q  <= hold_d;
      full_q  <= full_d;
      if (apply_en) word_q <= word_d;
      upd_q   <= upd_d;
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/scpin_rx.sv
module scpin_rx
  import scpin_pkg::*;
#(
  parameter int unsigned N_SYNC  = SYNC_STAGES,
  parameter int unsigned N_FRAME = FRAME_BITS,
  parameter int unsigned N_FREQ  = FREQ_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_pin,
  input  logic [1:0]        pin_role,
  input  logic              field_start,
  input  logic              line_start,
  output logic              sc_reset_pulse,
  output logic [N_FREQ-1:0] freq_word,
  output logic              freq_update
);
  logic      srst_n;
  logic      pin_level;
  logic      pin_rise;
  pin_role_e role;
  logic      role_reset;
  logic      role_serial;

  assign role        = pin_role_e'(pin_role);
  assign role_reset  = (role == ROLE_RESET);
  assign role_serial = (role == ROLE_SERIAL);

  scpin_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  scpin_pin_sync #(.STAGES(N_SYNC)) u_sync (
    .clk     (clk),
    .rst_n   (srst_n),
    .pin_i   (ctl_pin),
    .level_o (pin_level),
    .rise_o  (pin_rise)
  );

  scpin_rst_arm u_arm (
    .clk     (clk),
    .rst_n   (srst_n),
    .role_en (role_reset),
    .rise_i  (pin_rise),
    .field_i (field_start),
    .pulse_o (sc_reset_pulse)
  );

  scpin_rtc_deser #(.FRAME_BITS(N_FRAME), .WORD_BITS(N_FREQ)) u_deser (
    .clk     (clk),
    .rst_n   (srst_n),
    .role_en (role_serial),
    .level_i (pin_level),
    .rise_i  (pin_rise),
    .line_i  (line_start),
    .word_o  (freq_word),
    .upd_o   (freq_update)
  );
endmodule

// File: rtl/scpin_rx_chk.sv
module scpin_rx_chk #(
  parameter int unsigned N_FREQ = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        pin_role,
  input logic              field_start,
  input logic              line_start,
  input logic              sc_reset_pulse,
  input logic [N_FREQ-1:0] freq_word,
  input logic              freq_update
);
  assert_pulse_after_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_reset_pulse |-> ($past(field_start) && $past(pin_role) == 2'b01));

  assert_no_pulse_outside_reset_role_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_role != 2'b01) |=> !sc_reset_pulse);

  assert_update_only_serial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    freq_update |-> ($past(pin_role) == 2'b10));

  assert_update_after_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    freq_update |-> $past(line_start));

  assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_update |-> $stable(freq_word));
endmodule

bind scpin_rx scpin_rx_chk #(.N_FREQ(N_FREQ)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .pin_role       (pin_role),
  .field_start    (field_start),
  .line_start     (line_start),
  .sc_reset_pulse (sc_reset_pulse),
  .freq_word      (freq_word),
  .freq_update    (freq_update)
);

// File: tb/scpin_rx_tb_top.sv
module scpin_rx_tb_top;
  logic        clk;
  logic        rst_n;
  logic        pin;
  logic [1:0]  role;
  logic        fs;
  logic        ls;
  logic        pulse;
  logic [21:0] word;
  logic        upd;

  int compared;
  int mismatched;
  int n_pulse;
  int n_upd;
  int wd;

  scpin_rx dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_pin        (pin),
    .pin_role       (role),
    .field_start    (fs),
    .line_start     (ls),
    .sc_reset_pulse (pulse),
    .freq_word      (word),
    .freq_update    (upd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int          pin_q[$];
  bit          m_pend, m_busy, m_full;
  int          m_cyc;
  logic [21:0] m_cap, m_hold, e_word;
  bit          e_pulse, e_upd;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_q = {0, 0, 0};
      m_pend = 0; m_busy = 0; m_full = 0; m_cyc = 0;
      m_cap = '0; m_hold = '0; e_word = '0; e_pulse = 0; e_upd = 0;
    end else begin
      int cur, prv, k;
      bit rise;
      cur = pin_q[1];
      prv = pin_q[2];
      rise = (cur == 1) && (prv == 0);
      e_pulse = 0;
      e_upd = 0;
      if (role == 2'b01) begin
        if (fs) begin e_pulse = m_pend; m_pend = rise; end
        else if (rise) m_pend = 1;
      end else m_pend = 0;
      if (role == 2'b10) begin
        if (ls && m_full) begin e_word = m_hold; e_upd = 1; m_full = 0; end
        if (m_busy) begin
          m_cyc++;
          if (m_cyc >= 3 && ((m_cyc - 3) % 2) == 0) begin
            k = (m_cyc - 3) / 2;
            if (k < 22) m_cap[k] = cur[0];
            if (k == 66) begin m_busy = 0; m_hold = m_cap; m_full = 1; end
          end
        end else if (rise) begin
          m_busy = 1; m_cyc = 0;
        end
      end else begin
        m_busy = 0; m_full = 0;
      end
      pin_q.push_front(int'(pin));
      void'(pin_q.pop_back());
    end
  end

  // per-cycle comparison and event counting, away from the active edge
  always @(negedge clk) begin
    compared += 3;
    if (pulse !== e_pulse) begin
      mismatched++;
      $display("FAIL R3 sc_reset_pulse actual=%0b expected=%0b t=%0t", pulse, e_pulse, $time);
    end
    if (upd !== e_upd) begin
      mismatched++;
      $display("FAIL R7 freq_update actual=%0b expected=%0b t=%0t", upd, e_upd, $time);
    end
    if (word !== e_word) begin
      mismatched++;
      $display("FAIL R6 freq_word actual=%h expected=%h t=%0t", word, e_word, $time);
    end
    if (pulse === 1'b1) n_pulse++;
    if (upd === 1'b1) n_upd++;
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 100000) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic field_pulse();
    fs = 1'b1; step(1); fs = 1'b0;
  endtask

  task automatic line_pulse();
    ls = 1'b1; step(1); ls = 1'b0;
  endtask

  task automatic send_frame(input logic [66:0] f);
    pin = 1'b1; step(2);
    for (int i = 0; i < 67; i++) begin
      pin = f[i]; step(2);
    end
    pin = 1'b0; step(1);
  endtask

  localparam logic [66:0] FR_A = {45'h0DEADBEEFCAF, 22'h2A5C31};
  localparam logic [66:0] FR_B = {45'h155555555555, 22'h15A5A5};
  localparam logic [66:0] FR_C = {45'h0F0F0F0F0F0F, 22'h3C0F01};
  localparam logic [66:0] FR_D = {45'h1FFFFFFFFFFF, 22'h00F3A7};

  initial begin
    int p0, u0;
    compared = 0; mismatched = 0; n_pulse = 0; n_upd = 0; wd = 0;
    rst_n = 1'b0; pin = 1'b0; role = 2'b00; fs = 1'b0; ls = 1'b0;
    step(3);
    chk(pulse === 1'b0, "R1 pulse in reset", int'(pulse), 0);
    chk(upd === 1'b0, "R1 update in reset", int'(upd), 0);
    chk(word === 22'h0, "R1 word in reset", int'(word), 0);
    rst_n = 1'b1;
    step(6);
    chk(word === 22'h0 && n_pulse == 0, "R1 idle after release", int'(word), 0);

    // R3: arm then fire at the boundary only
    role = 2'b01; step(2);
    p0 = n_pulse;
    pin = 1'b1; step(3); pin = 1'b0; step(4);
    chk(n_pulse == p0, "R3 no pulse before boundary", n_pulse - p0, 0);
    field_pulse(); step(3);
    chk(n_pulse == p0 + 1, "R3 pulse at boundary", n_pulse - p0, 1);

    // R4: several edges, one pulse, then none
    p0 = n_pulse;
    pin = 1'b1; step(2); pin = 1'b0; step(2);
    pin = 1'b1; step(2); pin = 1'b0; step(4);
    field_pulse(); step(3);
    chk(n_pulse == p0 + 1, "R4 single pulse", n_pulse - p0, 1);
    field_pulse(); step(3);
    chk(n_pulse == p0 + 1, "R4 no repeat", n_pulse - p0, 1);

    // R3: edge coinciding with boundary arms the following one
    p0 = n_pulse;
    pin = 1'b1; step(2); fs = 1'b1; step(1); fs = 1'b0; pin = 1'b0; step(3);
    chk(n_pulse == p0, "R3 coincident edge not fired", n_pulse - p0, 0);
    field_pulse(); step(3);
    chk(n_pulse == p0 + 1, "R3 coincident edge fires next field", n_pulse - p0, 1);

    // R5: role change drops the armed reset
    p0 = n_pulse;
    pin = 1'b1; step(3); pin = 1'b0; step(3);
    role = 2'b00; step(2); role = 2'b01; step(2);
    field_pulse(); step(3);
    chk(n_pulse == p0, "R5 cleared by role change", n_pulse - p0, 0);

    // R2: off roles ignore everything; reset role decodes no frame
    p0 = n_pulse; u0 = n_upd;
    role = 2'b00;
    pin = 1'b1; step(3); pin = 1'b0; step(3); field_pulse(); line_pulse(); step(3);
    role = 2'b11;
    pin = 1'b1; step(3); pin = 1'b0; step(3); field_pulse(); line_pulse(); step(3);
    chk(n_pulse == p0, "R2 off roles no pulse", n_pulse - p0, 0);
    chk(n_upd == u0, "R2 off roles no update", n_upd - u0, 0);
    role = 2'b01; step(2);
    send_frame(FR_A); step(4); line_pulse(); step(3);
    chk(n_upd == u0, "R2 reset role decodes no frame", n_upd - u0, 0);
    role = 2'b00; step(2);
    field_pulse(); step(2);

    // R6 R7 R8: serial frame, mid-frame line start ignored
    role = 2'b10; step(4);
    p0 = n_pulse; u0 = n_upd;
    fork
      send_frame(FR_A);
      begin step(40); line_pulse(); step(10); field_pulse(); end
    join
    chk(n_upd == u0, "R7 no update before frame complete", n_upd - u0, 0);
    chk(n_pulse == p0, "R2 serial role no reset pulse", n_pulse - p0, 0);
    step(4); line_pulse(); step(2);
    chk(n_upd == u0 + 1, "R7 update on line start", n_upd - u0, 1);
    chk(word === FR_A[21:0], "R6 word bits 0..21", int'(word), int'(FR_A[21:0]));
    line_pulse(); step(2);
    chk(n_upd == u0 + 1 && word === FR_A[21:0], "R7 no second update", n_upd - u0, 1);

    // R6 second frame with alternating data
    send_frame(FR_B); step(4); line_pulse(); step(2);
    chk(word === FR_B[21:0], "R6 R8 second word", int'(word), int'(FR_B[21:0]));

    // R9: abort mid-frame
    u0 = n_upd;
    fork
      send_frame(FR_C);
      begin step(50); role = 2'b00; end
    join
    step(6); role = 2'b10; step(4);
    line_pulse(); step(2);
    chk(n_upd == u0, "R9 aborted frame not applied", n_upd - u0, 0);

    // R9: completed but unapplied word is discarded
    send_frame(FR_C); step(4);
    role = 2'b00; step(2); role = 2'b10; step(2);
    line_pulse(); step(2);
    chk(n_upd == u0 && word === FR_B[21:0], "R9 pending word discarded", int'(word), int'(FR_B[21:0]));

    send_frame(FR_D); step(4); line_pulse(); step(2);
    chk(word === FR_D[21:0], "R6 word after recovery", int'(word), int'(FR_D[21:0]));
    step(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule